// File: doc/BRIEF.md
# Idle-Locked Serial Descrambler

This block takes the 125 Mbit/s serial bit stream that arrives after line decoding and removes the far-end scrambling. The scrambling is an additive stream cipher driven by an 11-bit LFSR with polynomial x^11 + x^9 + 1. The far end seeds its LFSR from its own port address, so every link runs a different sequence. The receiver therefore never assumes a seed. While the line carries idle, which is all ones before scrambling, each received bit is the inverse of the key bit. The block shifts eleven such bits into its key register, runs the register freely from then on, and confirms the key by counting consecutive descrambled ones before it declares lock.

Once locked, a watchdog counts bit times. Any run of ten or more descrambled ones counts as idle and restarts the window. If the window runs out without idle, the block drops lock, pulses an abort flag to stop the frame in progress, and starts acquisition again. The default window is 16384 bits. That is longer than a maximum-size frame with its preamble (about 15260 code bits), so a legal frame never trips it. A bypass input passes the received bit straight to the output. A 5-bit serial-to-parallel stage groups the output bits for the code-group aligner that follows.

Top module: `idle_descrambler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `locked`, `abort`, `out_valid` and `word_valid` are 0.
- R2: After lock, `out_bit` equals the far end's unscrambled bit for every bit. The key is derived only from the 11 bits received while idle.
- R3: Starting from acquisition on an idle line, `locked` goes to 1 on exactly the 41st valid bit (11 key-load bits plus 30 confirming ones) and not before.
- R4: A descrambled 0 during confirmation restarts acquisition. After it, 41 further idle bits are needed before `locked` rises.
- R5: While locked, 16384 consecutive valid bits with no run of 10 descrambled ones make `locked` fall and `abort` pulse high for exactly one clock, both on the 16384th bit. Acquisition then restarts as in R3.
- R6: While locked, a run of 10 descrambled ones restarts the watchdog window.
- R7: A non-idle stretch of 15260 bits (a maximum-size frame) while locked causes no abort.
- R8: With `bypass` high, `out_bit` equals `rx_bit` of the same bit, and acquisition and lock behave as without bypass.
- R9: A cycle with `bit_en` low changes neither `out_bit` nor the lock state.
- R10: Every fifth valid output bit since reset raises `word_valid` in the same cycle as that bit's `out_valid`. `word` then holds the last five output bits, the oldest in bit 4 and the newest in bit 0.
- R11: `out_valid` is 1 exactly in the cycle after each clock edge that sampled `bit_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies `rx_bit` in this cycle |
| rx_bit | input | 1 | Received scrambled bit |
| bypass | input | 1 | 1 passes `rx_bit` to the output undescrambled |
| out_bit | output | 1 | Descrambled (or bypassed) bit, registered |
| out_valid | output | 1 | `out_bit` was updated at the last edge |
| locked | output | 1 | Key acquired and confirmed |
| abort | output | 1 | One-clock pulse when the idle watchdog expires |
| word | output | 5 | Last five output bits, oldest in the MSB |
| word_valid | output | 1 | `word` is complete this cycle |

## Verification
The assertions assume that `bit_en`, `rx_bit` and `bypass` carry known values from the first clock after reset. Nothing beyond that is assumed: any pattern of gaps in `bit_en` and any bypass setting is legal input. The stimulus drives every input to a defined level at time zero and changes inputs only at the falling edge. The idle and data streams come from a bench copy of the far-end scrambler with its own address-derived seed. The data patterns are chosen with known maximum runs of ones, so the bench knows exactly when the watchdog must and must not expire.

// File: rtl/idsc_pkg.sv
package idsc_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } sync_state_e;
endpackage

// File: rtl/dscr_key.sv
module dscr_key #(
  parameter int KEY_W = 11,
  parameter int TAP_A = 10,
  parameter int TAP_B = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic load,
  input  logic rx_bit,
  output logic desc_bit
);
  logic [KEY_W-1:0] key_q, key_d;
  logic             gen;

  assign gen      = key_q[TAP_A] ^ key_q[TAP_B];
  assign desc_bit = rx_bit ^ gen;

  always_comb begin
    key_d = key_q;
    if (bit_en) begin
      key_d = {key_q[KEY_W-2:0], (load ? ~rx_bit : gen)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_d;
  end

  // R9: key only moves on a qualified bit
  assert_key_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(key_q));
endmodule

// File: rtl/dscr_sync.sv
module dscr_sync
  import idsc_pkg::*;
#(
  parameter int LOAD_BITS = 11,
  parameter int LOCK_RUN  = 30,
  parameter int IDLE_RUN  = 10,
  parameter int WINDOW    = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic desc_bit,
  output logic load_key,
  output logic locked,
  output logic abort
);
  localparam int AQ_MAX = (LOAD_BITS > LOCK_RUN) ? LOAD_BITS : LOCK_RUN;
  localparam int AQ_W   = $clog2(AQ_MAX + 1);
  localparam int RUN_W  = $clog2(IDLE_RUN + 1);
  localparam int WD_W   = $clog2(WINDOW + 1);
  localparam logic [AQ_W-1:0]  AQ_LOAD_LAST = AQ_W'(LOAD_BITS - 1);
  localparam logic [AQ_W-1:0]  AQ_LOCK_LAST = AQ_W'(LOCK_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_FULL     = RUN_W'(IDLE_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST     = RUN_W'(IDLE_RUN - 1);
  localparam logic [WD_W-1:0]  WD_LAST      = WD_W'(WINDOW - 1);

  sync_state_e      state_q, state_d;
  logic [AQ_W-1:0]  acq_q, acq_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [WD_W-1:0]  wd_q, wd_d;
  logic             abort_q, abort_d;
  logic             idle_seen;

  assign idle_seen = desc_bit && (run_q >= RUN_LAST);

  always_comb begin
    state_d = state_q;
    acq_d   = acq_q;
    run_d   = run_q;
    wd_d    = wd_q;
    abort_d = 1'b0;
    if (bit_en) begin
      unique case (state_q)
        ST_HUNT: begin
          if (acq_q == AQ_LOAD_LAST) begin
            state_d = ST_CONFIRM;
            acq_d   = '0;
          end else begin
            acq_d = acq_q + 1'b1;
          end
        end
        ST_CONFIRM: begin
          if (!desc_bit) begin
            state_d = ST_HUNT;
            acq_d   = '0;
          end else if (acq_q == AQ_LOCK_LAST) begin
            state_d = ST_LOCKED;
            acq_d   = '0;
            run_d   = '0;
            wd_d    = '0;
          end else begin
            acq_d = acq_q + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (!desc_bit)             run_d = '0;
          else if (run_q != RUN_FULL) run_d = run_q + 1'b1;
          if (idle_seen) begin
            wd_d = '0;
          end else if (wd_q == WD_LAST) begin
            abort_d = 1'b1;
            state_d = ST_HUNT;
            acq_d   = '0;
          end else begin
            wd_d = wd_q + 1'b1;
          end
        end
        default: begin
          state_d = ST_HUNT;
          acq_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      acq_q   <= '0;
      run_q   <= '0;
      wd_q    <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      acq_q   <= acq_d;
      run_q   <= run_d;
      wd_q    <= wd_d;
      abort_q <= abort_d;
    end
  end

  assign load_key = (state_q == ST_HUNT);
  assign locked   = (state_q == ST_LOCKED);
  assign abort    = abort_q;

  assert_wd_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_q <= WD_LAST);
  assert_abort_from_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> ($past(state_q) == ST_LOCKED) && (state_q == ST_HUNT));
  assert_lock_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED) && ($past(state_q) != ST_LOCKED)
      |-> ($past(state_q) == ST_CONFIRM) && $past(desc_bit) && $past(bit_en));
  assert_state_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(state_q));
endmodule

// File: rtl/dscr_sipo.sv
module dscr_sipo #(
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q, sr_d, word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wv_q, wv_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    word_d = word_q;
    wv_d   = 1'b0;
    if (bit_en) begin
      sr_d = {sr_q[WORD_W-2:0], bit_in};
      if (cnt_q == CNT_LAST) begin
        cnt_d  = '0;
        word_d = sr_d;
        wv_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      wv_q   <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      word_q <= word_d;
      wv_q   <= wv_d;
    end
  end

  assign word       = word_q;
  assign word_valid = wv_q;

  assert_cnt_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  assert_word_after_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q |-> $past(bit_en) && (cnt_q == '0) && (word_q[0] == $past(bit_in)));
endmodule

// File: rtl/idle_descrambler.sv
module idle_descrambler #(
  parameter int KEY_W     = 11,
  parameter int LOCK_RUN  = 30,
  parameter int IDLE_RUN  = 10,
  parameter int WINDOW    = 16384,
  parameter int WORD_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              bypass,
  output logic              out_bit,
  output logic              out_valid,
  output logic              locked,
  output logic              abort,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);
  logic desc_bit, load_key, chosen;
  logic out_bit_q, out_bit_d, out_valid_q;

  dscr_key #(.KEY_W(KEY_W), .TAP_A(KEY_W-1), .TAP_B(KEY_W-3)) u_key (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load_key),
    .rx_bit(rx_bit), .desc_bit(desc_bit));

  dscr_sync #(.LOAD_BITS(KEY_W), .LOCK_RUN(LOCK_RUN), .IDLE_RUN(IDLE_RUN),
              .WINDOW(WINDOW)) u_sync (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .desc_bit(desc_bit),
    .load_key(load_key), .locked(locked), .abort(abort));

  assign chosen = bypass ? rx_bit : desc_bit;

  dscr_sipo #(.WORD_W(WORD_W)) u_sipo (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(chosen),
    .word(word), .word_valid(word_valid));

  always_comb begin
    out_bit_d = out_bit_q;
    if (bit_en) out_bit_d = chosen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bit_q   <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      out_bit_q   <= out_bit_d;
      out_valid_q <= bit_en;
    end
  end

  assign out_bit   = out_bit_q;
  assign out_valid = out_valid_q;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(out_bit) && !out_valid);
  assert_abort_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !locked);
  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass && bit_en |=> out_bit == $past(rx_bit));
  assert_word_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> out_valid && (word[0] == out_bit));
endmodule

// File: tb/idle_descrambler_bench.sv
module idle_descrambler_bench;
  logic       clk, rst_n, bit_en, rx_bit, bypass;
  logic       out_bit, out_valid, locked, abort, word_valid;
  logic [4:0] word;

  int unsigned n_checks, n_fail, nbits, abort_seen;
  logic [10:0] sk;
  logic [4:0]  hist;
  logic        last_rx, last_plain;

  idle_descrambler u_idle_descrambler (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .bypass(bypass), .out_bit(out_bit), .out_valid(out_valid),
    .locked(locked), .abort(abort), .word(word), .word_valid(word_valid));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // one bit through the far-end scrambler model, checked at the falling edge
  task automatic send(input logic plain);
    logic g;
    g = sk[10] ^ sk[8];
    sk = {sk[9:0], g};
    rx_bit = plain ^ g;
    last_rx = rx_bit;
    last_plain = plain;
    bit_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (abort) abort_seen++;
    check(out_valid == 1'b1, "R11", out_valid, 1);
    if (bypass)      check(out_bit == last_rx, "R8", out_bit, last_rx);
    else if (locked) check(out_bit == last_plain, "R2", out_bit, last_plain);
    nbits++;
    hist = {hist[3:0], out_bit};
    if (nbits % 5 == 0) begin
      check(word_valid == 1'b1, "R10", word_valid, 1);
      check(word == hist, "R10", word, hist);
    end else begin
      check(word_valid == 1'b0, "R10", word_valid, 0);
    end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      logic ob, lk;
      ob = out_bit;
      lk = locked;
      bit_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R11", out_valid, 0);
      check(out_bit == ob, "R9", out_bit, ob);
      check(locked == lk, "R9", locked, lk);
      check(word_valid == 1'b0, "R10", word_valid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0; nbits = 0; abort_seen = 0; hist = '0;
    sk = {5'b10110, 6'h13};
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; bypass = 1'b0;
    last_rx = 1'b0; last_plain = 1'b0;
    repeat (3) @(negedge clk);
    check(!locked && !abort && !out_valid && !word_valid, "R1", locked, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!locked && !abort && !out_valid && !word_valid, "R1", out_valid, 0);

    // R3: lock on the 41st idle bit
    for (int i = 0; i < 40; i++) send(1'b1);
    check(locked == 1'b0, "R3", locked, 0);
    send(1'b1);
    check(locked == 1'b1, "R3", locked, 1);

    // R2: data patterns descrambled
    for (int i = 0; i < 60; i++) send(1'(i % 2));
    for (int i = 0; i < 60; i++) send(1'((i / 3) % 2));
    for (int i = 0; i < 60; i++) send(1'(i % 5 != 0));
    check(locked == 1'b1, "R2", locked, 1);

    // R9: gaps
    gap(4);
    for (int i = 0; i < 7; i++) send(1'(i % 3 == 0));
    gap(1);

    // R8: bypass while locked
    bypass = 1'b1;
    for (int i = 0; i < 23; i++) send(1'(i % 4 == 1));
    bypass = 1'b0;
    check(locked == 1'b1, "R8", locked, 1);

    // R7: max frame after idle
    for (int i = 0; i < 12; i++) send(1'b1);
    abort_seen = 0;
    for (int i = 0; i < 15260; i++) send(1'(i % 5 != 0));
    check(locked == 1'b1 && abort_seen == 0, "R7", abort_seen, 0);

    // R6: idle run restarts window
    for (int i = 0; i < 10; i++) send(1'b1);
    for (int i = 0; i < 16000; i++) send(1'((i / 3) % 2));
    check(locked == 1'b1 && abort_seen == 0, "R6", abort_seen, 0);

    // R5: window exhausted
    for (int i = 0; i < 10; i++) send(1'b1);
    for (int i = 0; i < 16383; i++) send(1'(i % 5 != 0));
    check(locked == 1'b1 && abort_seen == 0, "R5", abort_seen, 0);
    send(1'b0);
    check(locked == 1'b0, "R5", locked, 0);
    check(abort == 1'b1, "R5", abort, 1);
    gap(1);
    check(abort == 1'b0, "R5", abort, 0);

    // R4: zero during confirmation restarts acquisition
    for (int i = 0; i < 20; i++) send(1'b1);
    send(1'b0);
    check(locked == 1'b0, "R4", locked, 0);
    for (int i = 0; i < 40; i++) send(1'b1);
    check(locked == 1'b0, "R4", locked, 0);
    send(1'b1);
    check(locked == 1'b1, "R4", locked, 1);
    for (int i = 0; i < 30; i++) send(1'((i / 2) % 2));

    report();
    $finish;
  end
endmodule